// File: doc/BRIEF.md
# Addressed Multidrop Serial Receiver

This block receives asynchronous serial frames on a shared multidrop line. Each frame is a low start bit, then eight or nine data bits sent least significant bit first, then a high stop bit. Every bit is sampled near its centre by counting an external oversampling tick. A missing stop bit raises a sticky framing-error flag.

When the address-filter enable is set, the block drops frames that are not meant for this node. An address frame is compared, one bit at a time under a mask, against a node address and against a broadcast pattern. The receive flag is raised only for frames addressed to this node or to all nodes.

Bit 7 of the control register has two uses, chosen by a select input. It reads as the framing-error flag when the select is 1, and as the upper mode bit when the select is 0. Writes to bit 7 follow the same choice.

Top module: `uart_addr_rx`

## Requirements
- R1: After reset, `rx_flag`, `fe_flag`, `ctl7_q`, `rx_bit9` and `rx_byte` are all 0, and the upper mode bit is 0.
- R2: The mode is {upper mode bit, `mode_lo`}. Mode 1 (0,1) receives frames of 8 data bits, LSB first. With `sm2_en` = 0, a frame whose stop bit is 1 loads `rx_byte` and sets `rx_flag`, and `rx_bit9` takes the stop bit.
- R3: Modes 2 and 3 (upper mode bit 1) receive frames of 9 data bits. The ninth bit goes to `rx_bit9`. With `sm2_en` = 0, every frame whose stop bit is 1 is accepted.
- R4: A frame whose stop bit samples 0 sets `fe_flag` and never sets `rx_flag`.
- R5: `fe_flag` stays set through later frames. Only a write of 0 through `ctl7_we` while `fe_sel` = 1 clears it.
- R6: `ctl7_q` reads `fe_flag` when `fe_sel` = 1 and the upper mode bit when `fe_sel` = 0. A write through `ctl7_we` while `fe_sel` = 0 changes only the upper mode bit.
- R7: In the 9-bit modes with `sm2_en` = 1, a frame whose ninth bit is 0 is dropped. A frame whose ninth bit is 1 is accepted only if its byte matches.
- R8: In mode 1 with `sm2_en` = 1, a frame is accepted only if its stop bit is 1 and its byte matches.
- R9: A byte matches when it equals `node_addr` in every bit where `addr_mask` is 1 (given address). It also matches when it has a 1 in every bit where `node_addr | addr_mask` is 1 (broadcast address).
- R10: In mode 0 (0,0) the receiver ignores the line, whatever `sm2_en` is. No flag changes.
- R11: A start bit that returns high before mid-bit (fewer than OVS/2 ticks low) is discarded and produces no frame.
- R12: `rx_flag` stays set until `ri_clr` is pulsed. While it is set, new frames leave `rx_byte` and `rx_bit9` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rxd | input | 1 | Serial line, idle high |
| os_tick | input | 1 | Oversampling tick, OVS ticks per bit |
| mode_lo | input | 1 | Lower mode bit |
| sm2_en | input | 1 | Address filter enable |
| node_addr | input | DW | Node address |
| addr_mask | input | DW | Address mask (1 = bit compared) |
| fe_sel | input | 1 | Selects the bit-7 function: 1 = framing error, 0 = upper mode bit |
| ctl7_we | input | 1 | Write strobe for bit 7 |
| ctl7_wd | input | 1 | Write data for bit 7 |
| ri_clr | input | 1 | Clears the receive flag |
| rx_byte | output | DW | Received byte |
| rx_bit9 | output | 1 | Ninth bit, or the stop bit in mode 1 |
| rx_flag | output | 1 | Receive flag |
| fe_flag | output | 1 | Framing-error flag |
| ctl7_q | output | 1 | Read value of bit 7 |

## Verification
The bench builds the block with the defaults, OVS = 16 and DW = 8, and gives one tick every two clocks. With these values the mid-bit sampling point, the half-bit glitch limit and the nine-bit shift all occur in a frame of a few hundred cycles. Random node addresses, masks and data, biased toward given and broadcast matches, then cover both filter outcomes in every mode many times over.

// File: rtl/uart_addr_rx.sv
module uart_addr_rx #(
  parameter int OVS = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rxd,
  input  logic          os_tick,
  input  logic          mode_lo,
  input  logic          sm2_en,
  input  logic [DW-1:0] node_addr,
  input  logic [DW-1:0] addr_mask,
  input  logic          fe_sel,
  input  logic          ctl7_we,
  input  logic          ctl7_wd,
  input  logic          ri_clr,
  output logic [DW-1:0] rx_byte,
  output logic          rx_bit9,
  output logic          rx_flag,
  output logic          fe_flag,
  output logic          ctl7_q
);
  localparam int CW  = $clog2(OVS);
  localparam int MID = OVS / 2 - 1;
  localparam int BW  = $clog2(DW + 2);

  typedef enum logic [1:0] {IDLE, START, DATA, STOP} st_t;
  st_t st;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bidx;
  logic [DW:0]   sh;
  logic          sm0;

  wire          nine     = sm0;
  wire          rx_on    = sm0 | mode_lo;
  wire [BW-1:0] last_idx = nine ? BW'(DW) : BW'(DW - 1);
  wire [DW-1:0] byte_now = nine ? sh[DW-1:0] : sh[DW:1];
  wire          done     = rx_on && os_tick && st == STOP && cnt == CW'(OVS - 1);
  wire          tag9     = nine ? sh[DW] : rxd;
  wire [DW-1:0] bcast    = node_addr | addr_mask;
  wire          given_ok = ((byte_now ^ node_addr) & addr_mask) == '0;
  wire          bcast_ok = (bcast & ~byte_now) == '0;
  wire          accept   = done && rxd && !rx_flag && (!sm2_en || (tag9 && (given_ok || bcast_ok)));

  assign ctl7_q = fe_sel ? fe_flag : sm0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= IDLE; cnt <= '0; bidx <= '0; sh <= '0;
    end else if (!rx_on) begin
      st <= IDLE;
    end else if (os_tick) begin
      case (st)
        IDLE:  if (!rxd) begin st <= START; cnt <= '0; end
        START: if (cnt == CW'(MID)) begin
                 st <= rxd ? IDLE : DATA; cnt <= '0; bidx <= '0;
               end else cnt <= cnt + CW'(1);
        DATA:  if (cnt == CW'(OVS - 1)) begin
                 cnt <= '0; sh <= {rxd, sh[DW:1]}; bidx <= bidx + BW'(1);
                 if (bidx == last_idx) st <= STOP;
               end else cnt <= cnt + CW'(1);
        STOP:  if (cnt == CW'(OVS - 1)) begin st <= IDLE; cnt <= '0; end
               else cnt <= cnt + CW'(1);
        default: st <= IDLE;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_flag <= 1'b0; rx_byte <= '0; rx_bit9 <= 1'b0;
    end else begin
      if (ri_clr) rx_flag <= 1'b0;
      if (accept) begin
        rx_flag <= 1'b1; rx_byte <= byte_now; rx_bit9 <= tag9;
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      fe_flag <= 1'b0; sm0 <= 1'b0;
    end else begin
      if (ctl7_we) begin
        if (fe_sel) fe_flag <= ctl7_wd;
        else sm0 <= ctl7_wd;
      end
      if (done && !rxd) fe_flag <= 1'b1;
    end

  assert_fe_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
    fe_flag && !(ctl7_we && fe_sel) |=> fe_flag);
  assert_fe_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fe_flag) |-> $past(st == STOP || ctl7_we));
  assert_ri_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flag && !ri_clr |=> rx_flag);
  assert_buf_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flag |=> $stable(rx_byte) && $stable(rx_bit9));
  assert_mode0_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_flag && !sm0 && !mode_lo |=> !rx_flag);
  assert_addr_tag_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_flag) && $past(sm2_en && sm0) |-> rx_bit9);
endmodule

// File: tb/sim_uart_addr_rx.sv
`timescale 1ns/1ps
module sim_uart_addr_rx;
  logic clk = 0, rst_n = 0, rxd = 1, ph = 0;
  logic mode_lo = 0, sm2_en = 0, fe_sel = 0, ctl7_we = 0, ctl7_wd = 0, ri_clr = 0;
  logic [7:0] node_addr = 0, addr_mask = 0, rx_byte;
  logic rx_bit9, rx_flag, fe_flag, ctl7_q;
  int n_chk = 0, n_fail = 0;
  bit m_sm0 = 0, m_ri = 0, m_b9 = 0, m_fe = 0;
  logic [7:0] m_byte = 0;

  always #2 clk = ~clk;
  always @(negedge clk) ph <= ~ph;

  uart_addr_rx #(.OVS(16), .DW(8)) u0 (
    .clk, .rst_n, .rxd, .os_tick(ph), .mode_lo, .sm2_en, .node_addr, .addr_mask,
    .fe_sel, .ctl7_we, .ctl7_wd, .ri_clr, .rx_byte, .rx_bit9, .rx_flag, .fe_flag, .ctl7_q);

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic hold(int n);
    repeat (2 * n) @(negedge clk);
  endtask

  function automatic bit addr_match(logic [7:0] b, logic [7:0] a, logic [7:0] m);
    return ((b & m) == (a & m)) || ((b | ~(a | m)) == 8'hFF);
  endfunction

  task automatic wr7(bit v);
    ctl7_wd = v; ctl7_we = 1; @(negedge clk); ctl7_we = 0;
    if (fe_sel) m_fe = v; else m_sm0 = v;
  endtask

  task automatic clr_ri;
    ri_clr = 1; @(negedge clk); ri_clr = 0; m_ri = 0;
  endtask

  task automatic set_mode(bit hi, bit lo);
    bit keep = fe_sel;
    fe_sel = 0; mode_lo = lo; wr7(hi); fe_sel = keep;
  endtask

  task automatic compare_all(string tag);
    chk(tag, "rx_flag", rx_flag, m_ri);
    chk(tag, "rx_byte", rx_byte, m_byte);
    chk(tag, "rx_bit9", rx_bit9, m_b9);
    chk(tag, "fe_flag", fe_flag, m_fe);
    chk(tag, "ctl7_q", ctl7_q, fe_sel ? m_fe : m_sm0);
  endtask

  task automatic frame(logic [7:0] d, bit d9, bit stp, string tag);
    bit nine = m_sm0, on = m_sm0 | mode_lo, acc;
    rxd = 0; hold(16);
    for (int i = 0; i < 8; i++) begin rxd = d[i]; hold(16); end
    if (nine) begin rxd = d9; hold(16); end
    rxd = stp; hold(16);
    rxd = 1; hold(20);
    if (on) begin
      if (!stp) m_fe = 1;
      acc = stp && !m_ri && (!sm2_en || ((nine ? d9 : 1'b1) && addr_match(d, node_addr, addr_mask)));
      if (acc) begin m_ri = 1; m_byte = d; m_b9 = nine ? d9 : stp; end
    end
    compare_all(tag);
  endtask

  initial begin
    #800000;
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4051));
    repeat (4) @(negedge clk);
    rst_n = 1; @(negedge clk);
    compare_all("R1");

    set_mode(0, 1);
    frame(8'hA5, 0, 1, "R2");
    chk("R2", "flag set", rx_flag, 1);
    frame(8'h3C, 0, 1, "R12");
    chk("R12", "byte kept", rx_byte, 8'hA5);
    clr_ri; chk("R12", "flag cleared", rx_flag, 0);

    rxd = 0; hold(5); rxd = 1; hold(40);
    compare_all("R11");

    frame(8'h5E, 0, 0, "R4");
    chk("R4", "fe set", fe_flag, 1);
    frame(8'h21, 0, 1, "R5");
    chk("R5", "fe kept", fe_flag, 1);
    clr_ri;
    fe_sel = 1; @(negedge clk); chk("R6", "ctl7 fe", ctl7_q, 1);
    fe_sel = 0; @(negedge clk); chk("R6", "ctl7 sm0", ctl7_q, 0);
    wr7(0); chk("R6", "fe unaffected", fe_flag, 1);
    fe_sel = 1; wr7(0); chk("R5", "fe cleared", fe_flag, 0);

    set_mode(1, 0);
    fe_sel = 0; @(negedge clk); chk("R6", "ctl7 sm0=1", ctl7_q, 1);
    frame(8'h77, 1, 1, "R3");
    chk("R3", "bit9", rx_bit9, 1); clr_ri;
    sm2_en = 1; node_addr = 8'h5A; addr_mask = 8'hF0;
    frame(8'h53, 1, 1, "R9"); chk("R9", "given", rx_flag, 1); clr_ri;
    frame(8'hFB, 1, 1, "R9"); chk("R9", "broadcast", rx_flag, 1); clr_ri;
    frame(8'h63, 1, 1, "R9"); chk("R9", "no match", rx_flag, 0);
    frame(8'h53, 0, 1, "R7"); chk("R7", "data frame dropped", rx_flag, 0);

    set_mode(0, 1);
    frame(8'h63, 0, 1, "R8"); chk("R8", "8-bit no match", rx_flag, 0);
    frame(8'h53, 0, 0, "R8"); chk("R8", "bad stop", rx_flag, 0);
    fe_sel = 1; wr7(0);
    set_mode(0, 0);
    frame(8'h53, 0, 0, "R10"); chk("R10", "mode0 idle", rx_flag, 0);
    chk("R10", "mode0 no fe", fe_flag, 0);

    for (int it = 0; it < 48; it++) begin
      int r = $urandom_range(0, 9);
      logic [7:0] d;
      bit d9 = 1'($urandom_range(0, 1)), stp = ($urandom_range(0, 6) != 0);
      string tag;
      if (r == 0) set_mode(0, 0);
      else if (r < 4) set_mode(0, 1);
      else set_mode(1, 1'($urandom_range(0, 1)));
      sm2_en = 1'($urandom_range(0, 1));
      node_addr = 8'($urandom); addr_mask = 8'($urandom);
      case ($urandom_range(0, 2))
        0: d = (node_addr & addr_mask) | (8'($urandom) & ~addr_mask);
        1: d = node_addr | addr_mask | 8'($urandom);
        default: d = 8'($urandom);
      endcase
      if ($urandom_range(0, 3) != 0 && m_ri) clr_ri;
      if ($urandom_range(0, 3) == 0) begin fe_sel = 1; wr7(0); end
      fe_sel = 1'($urandom_range(0, 1));
      if (!(m_sm0 | mode_lo)) tag = "R10";
      else if (!stp) tag = "R4";
      else if (sm2_en && m_sm0) tag = "R7";
      else if (sm2_en) tag = "R8";
      else if (m_sm0) tag = "R3";
      else tag = "R2";
      frame(d, d9, stp, tag);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule